// File: doc/BRIEF.md
# Flash Operation Status Poller

This block sits on the host side of an 8-bit parallel flash bus. It runs after software or another engine has issued a program or erase command. A single `start_i` pulse makes it run bus read cycles through the chip-enable and output-enable strobes. From the status bits it reads, it decides whether the embedded operation has finished. It then reports one `done_o` pulse together with `pass_o` or `fail_o`.

It supports two methods, chosen at start. The first is the toggle method: it compares bit 6 of two back-to-back reads, and falls back on bit 5, the timing-limit bit. The second is the data-polling method: it compares bit 7 of each read with bit 7 of an expected byte supplied by the requester. When an operation is found to be stuck, the block writes the reset command byte F0h to return the flash to array read. When an operation completes, the block makes one more read and returns that byte to the requester. Read access time, write pulse width and the poll limit are parameters counted in clock cycles.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, `fl_ce_n_o`, `fl_oe_n_o` and `fl_we_n_o` are 1, `fl_dq_oe_o` is 0, and `busy_o`, `done_o`, `pass_o` and `fail_o` are 0.
- R2: In toggle mode (`data_mode_i`=0), reads come in pairs. If bit 6 is equal in both reads of a pair, the block makes one further read, puts that byte on `result_o` and reports pass.
- R3: In toggle mode, if bit 6 differs within a pair and bit 5 of the second read is 0, the block starts a new pair.
- R4: In toggle mode, if bit 6 differs and bit 5 of the second read is 1, the block reads one more pair. If bit 6 is equal in that pair, the block makes the final read and reports pass.
- R5: If the re-check of R4 or R7 still shows the operation running, the block makes one write cycle of F0h and then reports fail.
- R6: In data-polling mode (`data_mode_i`=1), a read whose bit 7 equals bit 7 of `exp_data_i` is followed by one confirmation read. The confirmation byte goes on `result_o`. The result is pass if that byte equals `exp_data_i` in all 8 bits, and fail with no write cycle otherwise.
- R7: In data-polling mode, a read whose bit 7 does not match and whose bit 5 is 1 is followed by one more read. A match on that read is handled as in R6.
- R8: After `MAX_POLLS` unresolved rounds (a round is one pair in toggle mode, one read in data mode) with bit 5 low, the block writes F0h and reports fail.
- R9: While `hold_i` is 1, no read cycle starts. In toggle mode, the first read after `hold_i` falls is the first read of a new pair.
- R10: A read cycle holds `fl_ce_n_o` and `fl_oe_n_o` low for exactly `T_RD` clocks. A write cycle holds `fl_ce_n_o` and `fl_we_n_o` low for exactly `T_WP` clocks with `fl_dq_oe_o` high. At least one clock with all strobes high separates cycles. `fl_oe_n_o` and `fl_we_n_o` are never low together.
- R11: `done_o` is a one-clock pulse with exactly one of `pass_o` and `fail_o` set. It rises R·(`T_RD`+2) + W·(`T_WP`+2) clocks after the clock edge that samples `start_i`, where R is the number of reads and W the number of writes.
- R12: `start_i` is ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a status poll (taken only when idle) |
| data_mode_i | input | 1 | 0 selects the toggle method, 1 selects data polling |
| exp_data_i | input | 8 | Expected byte for data polling |
| addr_i | input | ADDR_W | Address used for status reads |
| hold_i | input | 1 | Pause polling; on resume a new pair starts |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-clock completion pulse |
| pass_o | output | 1 | Operation succeeded (held until next start) |
| fail_o | output | 1 | Operation failed (held until next start) |
| result_o | output | 8 | Byte from the final read after completion |
| fl_addr_o | output | ADDR_W | Flash address bus |
| fl_dq_o | output | 8 | Flash data bus, driven value |
| fl_dq_oe_o | output | 1 | Data bus output enable |
| fl_dq_i | input | 8 | Flash data bus, sampled value |
| fl_ce_n_o | output | 1 | Chip enable, active low |
| fl_oe_n_o | output | 1 | Output enable, active low |
| fl_we_n_o | output | 1 | Write enable, active low |

## Verification
The assertions assume that `fl_dq_i` is settled by the last clock of each read strobe, and that a requester pulses `start_i` without waiting on any handshake. The flash model in the bench meets the first assumption by changing its byte only after the output-enable strobe rises. `start_i` pulses are one clock long, and one of them deliberately lands mid-run to exercise R12. `hold_i` is raised only in the gap after a read has completed, which is where R9 gives it meaning. The checks on bit 5 and on timeouts assume the flash keeps toggling, or keeps bit 7 complemented, until the reset write. The model stops doing so once it sees F0h written.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    localparam int DQ_W     = 8;
    localparam int TOG_BIT  = 6;
    localparam int ERR_BIT  = 5;
    localparam int POLL_BIT = 7;
    localparam logic [DQ_W-1:0] RST_CMD = 8'hF0;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_ACT,
        BUS_REC
    } bus_st_e;

    typedef enum logic [1:0] {
        PL_IDLE,
        PL_ISSUE,
        PL_WAIT,
        PL_DONE
    } poll_st_e;

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int T_RD   = 3,
    parameter int T_WP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DQ_W-1:0]   wdata_i,
    output logic              ack_o,
    output logic              idle_o,
    output logic [DQ_W-1:0]   rdata_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [DQ_W-1:0]   fl_dq_o,
    output logic              fl_dq_oe_o,
    input  logic [DQ_W-1:0]   fl_dq_i,
    output logic              fl_ce_n_o,
    output logic              fl_oe_n_o,
    output logic              fl_we_n_o
);

    localparam int T_MAX = (T_RD > T_WP) ? T_RD : T_WP;
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(T_RD - 1);
    localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(T_WP - 1);

    typedef struct packed {
        bus_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   wdata;
        logic [DQ_W-1:0]   rdata;
    } bus_reg_t;

    bus_reg_t         q, d;
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt = q.wr ? WP_LAST : RD_LAST;

    always_comb begin
        d = q;
        unique case (q.st)
            BUS_IDLE: begin
                if (req_i) begin
                    d.st    = BUS_ACT;
                    d.cnt   = '0;
                    d.wr    = wr_i;
                    d.addr  = addr_i;
                    d.wdata = wdata_i;
                end
            end
            BUS_ACT: begin
                if (q.cnt == last_cnt) begin
                    d.st = BUS_REC;
                    if (!q.wr) begin
                        d.rdata = fl_dq_i;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            BUS_REC: d.st = BUS_IDLE;
            default: d.st = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ack_o      = (q.st == BUS_REC);
    assign idle_o     = (q.st == BUS_IDLE);
    assign rdata_o    = q.rdata;
    assign fl_addr_o  = q.addr;
    assign fl_dq_o    = q.wdata;
    assign fl_dq_oe_o = q.wr && (q.st != BUS_IDLE);
    assign fl_ce_n_o  = !(q.st == BUS_ACT);
    assign fl_oe_n_o  = !((q.st == BUS_ACT) && !q.wr);
    assign fl_we_n_o  = !((q.st == BUS_ACT) && q.wr);

    // R10
    ack_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> idle_o);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == BUS_ACT) && $past(q.st == BUS_ACT)) |-> $stable(fl_addr_o));

    // R10
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == BUS_ACT) |-> (q.cnt <= last_cnt));

endmodule

// File: rtl/flash_poll_fsm.sv
module flash_poll_fsm
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              data_mode_i,
    input  logic [DQ_W-1:0]   exp_data_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    input  logic              bus_idle_i,
    input  logic              bus_ack_i,
    input  logic [DQ_W-1:0]   bus_rdata_i,
    output logic              req_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DQ_W-1:0]   wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [DQ_W-1:0]   result_o
);

    localparam int PC_W = $clog2(MAX_POLLS + 1);
    localparam logic [PC_W-1:0] POLL_LIMIT = PC_W'(MAX_POLLS);

    typedef struct packed {
        poll_st_e          st;
        logic              dmode;
        logic [DQ_W-1:0]   exp;
        logic [ADDR_W-1:0] addr;
        logic              phase;
        logic              tog1;
        logic              recheck;
        logic              fin;
        logic              op_wr;
        logic [PC_W-1:0]   polls;
        logic              done;
        logic              pass;
        logic              fail;
        logic [DQ_W-1:0]   result;
    } fsm_reg_t;

    fsm_reg_t q, d;
    logic     resolved;
    logic     err_seen;
    logic     issue;
    logic     fin_ok;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        issue    = 1'b0;
        resolved = q.dmode ? (bus_rdata_i[POLL_BIT] == q.exp[POLL_BIT])
                           : (bus_rdata_i[TOG_BIT] == q.tog1);
        err_seen = bus_rdata_i[ERR_BIT];
        fin_ok   = q.dmode ? (bus_rdata_i == q.exp) : 1'b1;
        unique case (q.st)
            PL_IDLE: begin
                if (start_i) begin
                    d.st      = PL_ISSUE;
                    d.dmode   = data_mode_i;
                    d.exp     = exp_data_i;
                    d.addr    = addr_i;
                    d.phase   = 1'b0;
                    d.tog1    = 1'b0;
                    d.recheck = 1'b0;
                    d.fin     = 1'b0;
                    d.op_wr   = 1'b0;
                    d.polls   = '0;
                    d.pass    = 1'b0;
                    d.fail    = 1'b0;
                    d.result  = '0;
                end
            end
            PL_ISSUE: begin
                if (!q.op_wr && hold_i) begin
                    d.phase = 1'b0;
                end else if (bus_idle_i) begin
                    issue = 1'b1;
                    d.st  = PL_WAIT;
                end
            end
            PL_WAIT: begin
                if (bus_ack_i) begin
                    d.st = PL_ISSUE;
                    if (q.op_wr) begin
                        d.st   = PL_DONE;
                        d.done = 1'b1;
                        d.fail = 1'b1;
                    end else if (q.fin) begin
                        d.st     = PL_DONE;
                        d.done   = 1'b1;
                        d.result = bus_rdata_i;
                        d.pass   = fin_ok;
                        d.fail   = !fin_ok;
                    end else if (!q.dmode && !q.phase) begin
                        d.tog1  = bus_rdata_i[TOG_BIT];
                        d.phase = 1'b1;
                    end else begin
                        d.phase = 1'b0;
                        if (resolved) begin
                            d.fin = 1'b1;
                        end else if (q.recheck) begin
                            d.op_wr = 1'b1;
                        end else if (err_seen) begin
                            d.recheck = 1'b1;
                        end else begin
                            d.polls = q.polls + 1'b1;
                            if (d.polls == POLL_LIMIT) begin
                                d.op_wr = 1'b1;
                            end
                        end
                    end
                end
            end
            PL_DONE: d.st = PL_IDLE;
            default: d.st = PL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_o    = issue;
    assign wr_o     = q.op_wr;
    assign addr_o   = q.addr;
    assign wdata_o  = RST_CMD;
    assign busy_o   = (q.st != PL_IDLE);
    assign done_o   = q.done;
    assign pass_o   = q.pass;
    assign fail_o   = q.fail;
    assign result_o = q.result;

    // R11
    done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $onehot({pass_o, fail_o}));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    ack_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack_i |-> (q.st == PL_WAIT));

    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.polls <= POLL_LIMIT);

    // R5
    reset_write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack_i && wr_o) |=> (done_o && fail_o));

    // R2
    pass_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && pass_o) |-> $past(bus_ack_i && !wr_o));

    // R9
    hold_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && (q.st == PL_ISSUE) && !q.op_wr) |=> (q.st == PL_ISSUE));

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int T_RD      = 3,
    parameter int T_WP      = 2,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              data_mode_i,
    input  logic [7:0]        exp_data_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [7:0]        result_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_dq_o,
    output logic              fl_dq_oe_o,
    input  logic [7:0]        fl_dq_i,
    output logic              fl_ce_n_o,
    output logic              fl_oe_n_o,
    output logic              fl_we_n_o
);

    logic              bus_req;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DQ_W-1:0]   bus_wdata;
    logic              bus_ack;
    logic              bus_idle;
    logic [DQ_W-1:0]   bus_rdata;

    flash_poll_fsm #(
        .ADDR_W    (ADDR_W),
        .MAX_POLLS (MAX_POLLS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .data_mode_i (data_mode_i),
        .exp_data_i  (exp_data_i),
        .addr_i      (addr_i),
        .hold_i      (hold_i),
        .bus_idle_i  (bus_idle),
        .bus_ack_i   (bus_ack),
        .bus_rdata_i (bus_rdata),
        .req_o       (bus_req),
        .wr_o        (bus_wr),
        .addr_o      (bus_addr),
        .wdata_o     (bus_wdata),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .pass_o      (pass_o),
        .fail_o      (fail_o),
        .result_o    (result_o)
    );

    flash_bus_cycle #(
        .ADDR_W (ADDR_W),
        .T_RD   (T_RD),
        .T_WP   (T_WP)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (bus_req),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .ack_o      (bus_ack),
        .idle_o     (bus_idle),
        .rdata_o    (bus_rdata),
        .fl_addr_o  (fl_addr_o),
        .fl_dq_o    (fl_dq_o),
        .fl_dq_oe_o (fl_dq_oe_o),
        .fl_dq_i    (fl_dq_i),
        .fl_ce_n_o  (fl_ce_n_o),
        .fl_oe_n_o  (fl_oe_n_o),
        .fl_we_n_o  (fl_we_n_o)
    );

endmodule

// File: tb/flash_poll_ctrl_bench.sv
module flash_poll_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 19;
    localparam int TRD  = 3;
    localparam int TWP  = 2;
    localparam int MAXP = 8;
    localparam logic [7:0]    ARR    = 8'h5A;
    localparam logic [AW-1:0] ADDR_V = 19'h31234;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          data_mode = 1'b0;
    logic [7:0]    exp_data = ARR;
    logic          hold = 1'b0;
    logic          busy, done, pass, fail;
    logic [7:0]    result;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_o;
    logic          fl_dq_oe;
    logic [7:0]    fl_dq_i;
    logic          fl_ce_n, fl_oe_n, fl_we_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_poll_ctrl #(
        .ADDR_W    (AW),
        .T_RD      (TRD),
        .T_WP      (TWP),
        .MAX_POLLS (MAXP)
    ) u_flash_poll_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .data_mode_i (data_mode),
        .exp_data_i  (exp_data),
        .addr_i      (ADDR_V),
        .hold_i      (hold),
        .busy_o      (busy),
        .done_o      (done),
        .pass_o      (pass),
        .fail_o      (fail),
        .result_o    (result),
        .fl_addr_o   (fl_addr),
        .fl_dq_o     (fl_dq_o),
        .fl_dq_oe_o  (fl_dq_oe),
        .fl_dq_i     (fl_dq_i),
        .fl_ce_n_o   (fl_ce_n),
        .fl_oe_n_o   (fl_oe_n),
        .fl_we_n_o   (fl_we_n)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // flash model: status bytes while busy, array byte afterwards
    int busy_n  = 0;
    int err_at  = 1 << 20;
    int rd_idx  = 0;
    int wr_cnt  = 0;
    int rd_base = 0;
    int wr_base = 0;
    int oe_lo   = 0;
    int we_lo   = 0;

    function automatic logic [7:0] byte_at(int i);
        if (i >= busy_n) return ARR;
        return {1'b1, (i % 2) == 1, i >= err_at, 5'b0};
    endfunction

    always_comb begin
        int rel;
        rel = rd_idx - rd_base;
        if (wr_cnt != wr_base || rel >= busy_n) fl_dq_i = ARR;
        else fl_dq_i = {1'b1, (rel % 2) == 1, rel >= err_at, 5'b0};
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(!fl_oe_n && !fl_we_n), "R10", "oe/we overlap", 1, 0);
            if (!fl_oe_n) begin
                oe_lo++;
                chk(fl_addr == ADDR_V, "R10", "read address", int'(fl_addr), int'(ADDR_V));
            end else if (oe_lo != 0) begin
                chk(oe_lo == TRD, "R10", "read strobe width", oe_lo, TRD);
                rd_idx++;
                oe_lo = 0;
            end
            if (!fl_we_n) begin
                we_lo++;
                chk(fl_dq_oe && fl_dq_o == 8'hF0, "R5", "reset write byte", int'(fl_dq_o), 'hF0);
            end else if (we_lo != 0) begin
                chk(we_lo == TWP, "R10", "write strobe width", we_lo, TWP);
                wr_cnt++;
                we_lo = 0;
            end
        end
    end

    function automatic void predict(input bit dm, input logic [7:0] ev,
                                    output int nrd, output int nwr,
                                    output bit ps, output logic [7:0] rb);
        int i = 0;
        int polls = 0;
        bit rech = 0;
        logic [7:0] a, b;
        nrd = 0; nwr = 0; ps = 0; rb = 8'h00;
        while (i < 100000) begin
            if (!dm) begin
                a = byte_at(i); b = byte_at(i + 1); i += 2;
                if (a[6] == b[6]) begin nrd = i + 1; rb = byte_at(i); ps = 1; return; end
                if (rech) begin nrd = i; nwr = 1; return; end
                if (b[5]) rech = 1;
                else begin polls++; if (polls == MAXP) begin nrd = i; nwr = 1; return; end end
            end else begin
                a = byte_at(i); i += 1;
                if (a[7] == ev[7]) begin nrd = i + 1; rb = byte_at(i); ps = (rb == ev); return; end
                if (rech) begin nrd = i; nwr = 1; return; end
                if (a[5]) rech = 1;
                else begin polls++; if (polls == MAXP) begin nrd = i; nwr = 1; return; end end
            end
        end
    endfunction

    task automatic run_case(input bit dm, input int bn, input int ea,
                            input logic [7:0] ev, input bit poke, input string tag);
        int nrd, nwr, sigma;
        bit ps, seen;
        logic [7:0] rb;
        busy_n = bn; err_at = ea;
        rd_base = rd_idx; wr_base = wr_cnt;
        predict(dm, ev, nrd, nwr, ps, rb);
        sigma = nrd * (TRD + 2) + nwr * (TWP + 2);
        @(negedge clk);
        data_mode = dm; exp_data = ev; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int k = 0; k <= sigma + 4; k++) begin
            if (poke) begin
                start = (k == 5);
                data_mode = (k == 5) ? !dm : dm;
            end
            // R11 per-clock comparison of the completion pulse
            chk(done == (k == sigma), "R11", {tag, " done timing"}, k, sigma);
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        start = 1'b0; data_mode = dm;
        chk(seen, "R11", {tag, " done seen"}, seen, 1);
        chk(pass == ps && fail == !ps, tag, "pass flag", pass, ps);
        chk(rd_idx - rd_base == nrd, tag, "read count", rd_idx - rd_base, nrd);
        chk(wr_cnt - wr_base == nwr, tag, "reset writes", wr_cnt - wr_base, nwr);
        if (nwr == 0) chk(result == rb, tag, "result byte", int'(result), int'(rb));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1", "strobes idle", 0, 0);
        chk(!busy && !done && !pass && !fail, "R1", "status idle", 0, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(0, 0,    1 << 20, ARR,   0, "R2");
        run_case(0, 6,    1 << 20, ARR,   0, "R3");
        run_case(0, 4,    3,       ARR,   0, "R4");
        run_case(0, 1000, 2,       ARR,   0, "R5");
        run_case(0, 1000, 1 << 20, ARR,   0, "R8");
        run_case(1, 0,    1 << 20, ARR,   0, "R6");
        run_case(1, 3,    1 << 20, ARR,   0, "R6");
        run_case(1, 2,    1 << 20, 8'h5B, 0, "R6");
        run_case(1, 3,    2,       ARR,   0, "R7");
        run_case(1, 1000, 2,       ARR,   0, "R7");
        run_case(1, 1000, 1 << 20, ARR,   0, "R8");
        run_case(0, 6,    1 << 20, ARR,   1, "R12");

        // R9: hold after the first read of a pair restarts the pair
        busy_n = 6; err_at = 1 << 20;
        rd_base = rd_idx; wr_base = wr_cnt;
        @(negedge clk);
        data_mode = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (rd_idx - rd_base < 1) @(negedge clk);
        hold = 1'b1;
        repeat (6) begin
            @(negedge clk);
            chk(fl_ce_n, "R9", "no access during hold", fl_ce_n, 1);
        end
        chk(rd_idx - rd_base == 1, "R9", "reads during hold", rd_idx - rd_base, 1);
        hold = 1'b0;
        for (int k = 0; k < 500; k++) begin
            if (done) break;
            @(negedge clk);
        end
        chk(done && pass, "R9", "hold case pass", pass, 1);
        chk(rd_idx - rd_base == 8, "R9", "hold case read count", rd_idx - rd_base, 8);
        chk(result == ARR, "R9", "hold case result", int'(result), int'(ARR));
        @(negedge clk);
        chk(!done && !busy, "R11", "idle after done", busy, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule